// File: doc/BRIEF.md
# Stack-Oriented RISC Execution Core

A multi-cycle 32-bit processor core for a compact RISC instruction set. Each instruction is one 32-bit word. The core fetches it through a word-addressed memory request port, decodes and executes it, and then moves its byte-addressed instruction pointer (IP). There is no link register. Subroutine linkage goes through a memory stack. The stack pointer is a pseudo-register near the top of a register file whose size is set by a parameter. Conditions are held in N/Z flags and written into registers by explicit set instructions.

The memory port is valid/ready. The core raises `mem_req_valid` and holds address, write flag and write data unchanged until a cycle with `mem_req_ready` high completes the handshake. After that it waits for exactly one `mem_rsp_valid` pulse, which must be returned for every request, stores included. The core always accepts a response, so it has no response-side back-pressure. Only one request is outstanding at any time. The system-call port and the trap outputs are plain signals. The testbench preloads the program image, and system calls are serviced outside the core.

Top module: `stk_core`

## Requirements
- R1: Opcode is bits 31:26. Fields are a = 25:21, b = 20:16, c = 15:11. Three-register operations write ra = rb op rc, unsigned, low 32 bits kept, with opcodes (octal) ADD 00, SUB 01, MUL 02, DIV 03, MOD 04, AND 10, OR 11.
- R2: Register 0 reads as zero and writes to it are dropped. Writes to an index at or above the register count are also dropped, and such an index reads as zero.
- R3: CMP (20) sets Z = (ra == rb) and N = (ra < rb), unsigned. EQ 21, NE 22, LT 23, LE 24, GE 25 and GT 26 write 1 or 0 into ra. The conditions are Z, !Z, N, N|Z, !N and !Z&!N.
- R4: The immediate is bits 15:0, sign-extended. MOV (30) writes it to ra. LW (31) loads rb from byte address ra+imm. SW (32) stores rb to that address. The port carries the byte address divided by 4.
- R5: BEZ (40) adds imm*4 to IP when ra is zero. JMP (41) always adds imm*4. CALL (42) pushes IP+4 and then adds imm*4. RET (43) pops the new IP. Every other instruction adds 4.
- R6: PUSH (33) subtracts 4 from SP and then stores ra at the new SP. POP (34) loads ra from SP and then adds 4 to SP.
- R7: With D declared registers the file holds D+4 entries. BP is entry D+1, SP is D+2 and RV is D+3. After reset BP and SP equal the memory size in bytes, RV and the others are 0, IP is 0, and the first request is a read of word 0.
- R8: SYS (70) raises `sys_valid` for exactly one cycle with `sys_sp` set to SP. The core then issues no memory request until `sys_ack` arrives (an ack in the strobe cycle is ignored), and it resumes at IP+4.
- R9: Any opcode outside the list halts the core with cause 1. `halted` and `trap_cause` then hold until reset, and no further request or strobe occurs.
- R10: DIV or MOD with a zero divisor halts the core with cause 2 and writes no register.
- R11: A data address (LW, SW, PUSH, POP, CALL, RET) or a fetch IP whose low two bits are not zero halts the core with cause 3, and no memory access is made.
- R12: A request holds its address, write flag and data stable while not ready, and never overlaps a system-call strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = store, 0 = read |
| mem_req_addr | output | 30 | Word address (byte address bits 31:2) |
| mem_req_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | One-cycle response, one per request |
| mem_rsp_rdata | input | 32 | Read data |
| sys_valid | output | 1 | System-call strobe |
| sys_sp | output | 32 | SP value during the strobe |
| sys_ack | input | 1 | System call serviced |
| halted | output | 1 | Core stopped by a trap |
| trap_cause | output | 2 | 0 none, 1 illegal, 2 divide by zero, 3 unaligned |

## Verification
The first fetch request appears in the first cycle after reset is released. Each instruction then takes a request handshake, the response cycle, an execute cycle and, for memory instructions, a second handshake and response. How long that takes depends on randomly stalled ready, so the bench never counts fixed cycles. It samples at falling edges and waits on levels. `halted` rises in the cycle after the execute cycle of a trapping instruction, and the strobe appears in the cycle after SYS executes. Register results become visible only when a later SW writes them into the bench memory, so memory contents are compared only after the core has halted.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [5:0] {
    OP_ADD  = 6'o00, OP_SUB = 6'o01, OP_MUL = 6'o02, OP_DIV  = 6'o03, OP_MOD = 6'o04,
    OP_AND  = 6'o10, OP_OR  = 6'o11,
    OP_CMP  = 6'o20, OP_EQ  = 6'o21, OP_NE  = 6'o22, OP_LT   = 6'o23, OP_LE  = 6'o24,
    OP_GE   = 6'o25, OP_GT  = 6'o26,
    OP_MOV  = 6'o30, OP_LW  = 6'o31, OP_SW  = 6'o32, OP_PUSH = 6'o33, OP_POP = 6'o34,
    OP_BEZ  = 6'o40, OP_JMP = 6'o41, OP_CALL = 6'o42, OP_RET = 6'o43,
    OP_SYS  = 6'o70
  } opcode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE      = 2'd0,
    CAUSE_ILLEGAL   = 2'd1,
    CAUSE_DIVZERO   = 2'd2,
    CAUSE_UNALIGNED = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_EXEC, ST_MREQ, ST_MWAIT, ST_SYS, ST_SYSW, ST_HALT
  } state_e;

  typedef struct packed {
    opcode_e     op;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [4:0]  rc;
    logic [31:0] imm;
    logic        legal;
  } decoded_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [31:0] instr,
  output decoded_t    dec
);
  always_comb begin
    dec.op    = opcode_e'(instr[31:26]);
    dec.ra    = instr[25:21];
    dec.rb    = instr[20:16];
    dec.rc    = instr[15:11];
    dec.imm   = {{16{instr[15]}}, instr[15:0]};
    dec.legal = instr[31:26] inside {OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_AND,
                                     OP_OR, OP_CMP, OP_EQ, OP_NE, OP_LT, OP_LE, OP_GE,
                                     OP_GT, OP_MOV, OP_LW, OP_SW, OP_PUSH, OP_POP,
                                     OP_BEZ, OP_JMP, OP_CALL, OP_RET, OP_SYS};
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 32
) (
  input  opcode_e        op,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   res,
  output logic           div_zero
);
  logic y_zero;
  assign y_zero   = (y == '0);
  assign div_zero = y_zero && (op == OP_DIV || op == OP_MOD);

  always_comb begin
    unique case (op)
      OP_ADD:  res = x + y;
      OP_SUB:  res = x - y;
      OP_MUL:  res = x * y;
      OP_DIV:  res = y_zero ? '0 : x / y;
      OP_MOD:  res = y_zero ? '0 : x % y;
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int          NUM_REGS  = 16,
  parameter logic [31:0] STACK_TOP = 32'd4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_a_idx,
  input  logic [4:0]  rd_b_idx,
  input  logic [4:0]  rd_c_idx,
  output logic [31:0] rd_a,
  output logic [31:0] rd_b,
  output logic [31:0] rd_c,
  output logic [31:0] sp_q,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        sp_we,
  input  logic [31:0] sp_data
);
  localparam int         SLOTS  = 32;
  localparam int         BP_IDX = NUM_REGS - 3;
  localparam int         SP_IDX = NUM_REGS - 2;
  localparam logic [5:0] LIMIT  = 6'(NUM_REGS);

  logic [31:0] regs [SLOTS];
  logic        wr_ok;

  assign wr_ok = wr_en && (wr_idx != 5'd0) && ({1'b0, wr_idx} < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++)
        regs[i] <= (i == BP_IDX || i == SP_IDX) ? STACK_TOP : 32'd0;
    end else begin
      if (wr_ok)
        regs[wr_idx] <= wr_data;
      if (sp_we)
        regs[SP_IDX] <= sp_data;
    end
  end

  // Entries at or above NUM_REGS are never written and stay zero.
  assign rd_a = (rd_a_idx == 5'd0) ? 32'd0 : regs[rd_a_idx];
  assign rd_b = (rd_b_idx == 5'd0) ? 32'd0 : regs[rd_b_idx];
  assign rd_c = (rd_c_idx == 5'd0) ? 32'd0 : regs[rd_c_idx];
  assign sp_q = regs[SP_IDX];
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DECL_REGS = 12,
  parameter int MEM_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [29:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic        sys_valid,
  output logic [31:0] sys_sp,
  input  logic        sys_ack,
  output logic        halted,
  output logic [1:0]  trap_cause
);
  localparam int          NUM_REGS  = DECL_REGS + 4;
  localparam logic [31:0] STACK_TOP = 32'(MEM_BYTES);

  state_e      state;
  logic [31:0] ip, ir;
  logic        flag_n, flag_z;
  logic [31:0] m_addr, m_wdata;
  logic        m_we, ld_en, ret_pend;
  logic [4:0]  ld_dst;
  cause_e      cause_q;

  decoded_t    d;
  logic [31:0] rd_a, rd_b, rd_c, sp_q;
  logic [31:0] alu_res;
  logic        alu_dz;

  // execute-stage decisions
  logic        x_wr, x_sp_we, x_mem, x_we, x_ld, x_ret, x_flag, x_sys, cond;
  logic [31:0] x_data, x_sp, x_addr, x_wdata, x_ip, ip_seq, ip_br;
  logic [4:0]  x_ld_idx;
  cause_e      x_cause;

  logic        rf_we, rf_sp_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_data;

  stk_decode u_dec (.instr(ir), .dec(d));

  stk_alu #(.W(32)) u_alu (
    .op(d.op), .x(rd_b), .y(rd_c), .res(alu_res), .div_zero(alu_dz)
  );

  stk_regfile #(.NUM_REGS(NUM_REGS), .STACK_TOP(STACK_TOP)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(d.ra), .rd_b_idx(d.rb), .rd_c_idx(d.rc),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c), .sp_q(sp_q),
    .wr_en(rf_we), .wr_idx(rf_idx), .wr_data(rf_data),
    .sp_we(rf_sp_we), .sp_data(x_sp)
  );

  assign ip_seq = ip + 32'd4;
  assign ip_br  = ip + {d.imm[29:0], 2'b00};

  always_comb begin
    unique case (d.op)
      OP_EQ:   cond = flag_z;
      OP_NE:   cond = !flag_z;
      OP_LT:   cond = flag_n;
      OP_LE:   cond = flag_n || flag_z;
      OP_GE:   cond = !flag_n;
      default: cond = !flag_n && !flag_z;
    endcase
  end

  always_comb begin
    x_wr = 1'b0; x_data = '0; x_sp_we = 1'b0; x_sp = sp_q;
    x_mem = 1'b0; x_addr = '0; x_we = 1'b0; x_wdata = '0;
    x_ld = 1'b0; x_ld_idx = d.ra; x_ret = 1'b0; x_flag = 1'b0;
    x_sys = 1'b0; x_ip = ip_seq; x_cause = CAUSE_NONE;
    if (!d.legal) begin
      x_cause = CAUSE_ILLEGAL;
    end else begin
      unique case (d.op)
        OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD, OP_AND, OP_OR: begin
          if (alu_dz) x_cause = CAUSE_DIVZERO;
          else begin x_wr = 1'b1; x_data = alu_res; end
        end
        OP_CMP: x_flag = 1'b1;
        OP_EQ, OP_NE, OP_LT, OP_LE, OP_GE, OP_GT: begin
          x_wr = 1'b1; x_data = {31'd0, cond};
        end
        OP_MOV: begin x_wr = 1'b1; x_data = d.imm; end
        OP_LW: begin
          x_mem = 1'b1; x_addr = rd_a + d.imm; x_ld = 1'b1; x_ld_idx = d.rb;
        end
        OP_SW: begin
          x_mem = 1'b1; x_addr = rd_a + d.imm; x_we = 1'b1; x_wdata = rd_b;
        end
        OP_PUSH: begin
          x_mem = 1'b1; x_addr = sp_q - 32'd4; x_we = 1'b1; x_wdata = rd_a;
          x_sp_we = 1'b1; x_sp = sp_q - 32'd4;
        end
        OP_POP: begin
          x_mem = 1'b1; x_addr = sp_q; x_ld = 1'b1;
          x_sp_we = 1'b1; x_sp = sp_q + 32'd4;
        end
        OP_BEZ: if (rd_a == '0) x_ip = ip_br;
        OP_JMP: x_ip = ip_br;
        OP_CALL: begin
          x_mem = 1'b1; x_addr = sp_q - 32'd4; x_we = 1'b1; x_wdata = ip_seq;
          x_sp_we = 1'b1; x_sp = sp_q - 32'd4; x_ip = ip_br;
        end
        OP_RET: begin
          x_mem = 1'b1; x_addr = sp_q; x_ret = 1'b1;
          x_sp_we = 1'b1; x_sp = sp_q + 32'd4;
        end
        OP_SYS: x_sys = 1'b1;
        default: x_cause = CAUSE_ILLEGAL;
      endcase
      if (x_mem && x_addr[1:0] != 2'b00) x_cause = CAUSE_UNALIGNED;
    end
  end

  // register file write arbitration: execute results or load data
  always_comb begin
    if (state == ST_MWAIT) begin
      rf_we   = mem_rsp_valid && ld_en;
      rf_idx  = ld_dst;
      rf_data = mem_rsp_rdata;
    end else begin
      rf_we   = (state == ST_EXEC) && x_wr && (x_cause == CAUSE_NONE);
      rf_idx  = d.ra;
      rf_data = x_data;
    end
  end
  assign rf_sp_we = (state == ST_EXEC) && x_sp_we && (x_cause == CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FETCH; ip <= '0; ir <= '0; flag_n <= 1'b0; flag_z <= 1'b0;
      m_addr <= '0; m_wdata <= '0; m_we <= 1'b0; ld_en <= 1'b0; ld_dst <= '0;
      ret_pend <= 1'b0; cause_q <= CAUSE_NONE;
    end else begin
      unique case (state)
        ST_FETCH: begin
          if (ip[1:0] != 2'b00) begin
            cause_q <= CAUSE_UNALIGNED; state <= ST_HALT;
          end else if (mem_req_ready) state <= ST_FWAIT;
        end
        ST_FWAIT: if (mem_rsp_valid) begin ir <= mem_rsp_rdata; state <= ST_EXEC; end
        ST_EXEC: begin
          if (x_cause != CAUSE_NONE) begin
            cause_q <= x_cause; state <= ST_HALT;
          end else begin
            ip <= x_ip;
            if (x_flag) begin flag_z <= (rd_a == rd_b); flag_n <= (rd_a < rd_b); end
            if (x_mem) begin
              m_addr <= x_addr; m_we <= x_we; m_wdata <= x_wdata;
              ld_en <= x_ld; ld_dst <= x_ld_idx; ret_pend <= x_ret;
              state <= ST_MREQ;
            end else if (x_sys) state <= ST_SYS;
            else state <= ST_FETCH;
          end
        end
        ST_MREQ:  if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          if (ret_pend) ip <= mem_rsp_rdata;
          state <= ST_FETCH;
        end
        ST_SYS:  state <= ST_SYSW;
        ST_SYSW: if (sys_ack) state <= ST_FETCH;
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_FETCH && ip[1:0] == 2'b00) || state == ST_MREQ;
  assign mem_req_we    = (state == ST_MREQ) && m_we;
  assign mem_req_addr  = (state == ST_MREQ) ? m_addr[31:2] : ip[31:2];
  assign mem_req_wdata = m_wdata;
  assign sys_valid     = (state == ST_SYS);
  assign sys_sp        = sp_q;
  assign halted        = (state == ST_HALT);
  assign trap_cause    = cause_q;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [29:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        sys_valid,
  input logic        halted,
  input logic [1:0]  trap_cause
);
  // R12: a stalled request keeps its contents
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R12: memory request and system-call strobe never overlap
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && sys_valid));

  // R8: strobe lasts a single cycle
  a_r8_sys_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_valid |=> !sys_valid);

  // R9: halt and cause are sticky
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(trap_cause)));

  // R9: a halted core stays silent
  a_r9_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req_valid && !sys_valid));

  // R7: no cause is reported while running
  a_r7_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (trap_cause == 2'd0));
endmodule

bind stk_core stk_core_chk u_chk (.*);

// File: tb/stk_core_test.sv
module stk_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid, mem_req_we, sys_valid, halted;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, sys_ack = 1'b0;
  logic [29:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_rdata = '0, sys_sp;
  logic [1:0]  trap_cause;

  always #5 clk = ~clk;

  stk_core uut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .sys_valid(sys_valid), .sys_sp(sys_sp), .sys_ack(sys_ack),
    .halted(halted), .trap_cause(trap_cause)
  );

  localparam logic [31:0] FILL = 32'hDEADBEEF;
  localparam int          DATA = 512;   // word index of byte 0x800

  logic [31:0] mem [0:1023];
  int total = 0, bad = 0;
  int sys_cnt = 0, stall_bad = 0, ack_wait = 0;
  logic [31:0] sys_sp_seen = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e3(input logic [5:0] op, input logic [4:0] a, b, c);
    return {op, a, b, c, 11'd0};
  endfunction
  function automatic logic [31:0] ei(input logic [5:0] op, input logic [4:0] a, b,
                                     input logic [15:0] imm);
    return {op, a, b, imm};
  endfunction
  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [5:0] opc_of(input int code);
    case (code)
      0: return 6'o00; 1: return 6'o01; 2: return 6'o02; 3: return 6'o03;
      4: return 6'o04; 5: return 6'o10; 6: return 6'o11;
      default: return 6'(6'o21 + code - 7);
    endcase
  endfunction
  function automatic logic [31:0] exp_of(input int code, input logic [31:0] x, y);
    case (code)
      0: return x + y;  1: return x - y;  2: return x * y;
      3: return x / y;  4: return x % y;  5: return x & y;  6: return x | y;
      7: return {31'd0, x == y};  8: return {31'd0, x != y};
      9: return {31'd0, x < y};   10: return {31'd0, x <= y};
      11: return {31'd0, x >= y}; default: return {31'd0, x > y};
    endcase
  endfunction

  // memory and system-call responder, acting at falling edges
  initial begin
    logic        pend = 1'b0;
    logic [31:0] pend_data = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pend = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        sys_ack = 1'b0; ack_wait = 0;
      end else begin
        mem_rsp_valid = pend;
        mem_rsp_rdata = pend_data;
        mem_req_ready = ($urandom % 4) != 0;
        pend = mem_req_valid && mem_req_ready;
        if (pend) begin
          if (mem_req_we) mem[mem_req_addr[9:0]] = mem_req_wdata;
          pend_data = mem[mem_req_addr[9:0]];
        end
        sys_ack = 1'b0;
        if (ack_wait > 0) begin
          if (mem_req_valid) stall_bad++;
          ack_wait--;
          if (ack_wait == 0) sys_ack = 1'b1;
        end
        if (sys_valid) begin
          sys_cnt++; sys_sp_seen = sys_sp; ack_wait = 3;
        end
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = (i >= DATA && i < DATA + 256) ? FILL : 32'd0;
  endtask

  task automatic run_prog(input int limit);
    int cyc = 0;
    rst_n = 1'b0; sys_cnt = 0; stall_bad = 0;
    repeat (3) @(negedge clk);
    chk("R7 halted in reset", {31'd0, halted}, 32'd0);
    chk("R7 cause in reset", {30'd0, trap_cause}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 first request valid", {31'd0, mem_req_valid}, 32'd1);
    chk("R7 first request word 0", {2'b0, mem_req_addr}, 32'd0);
    while (!halted && cyc < limit) begin @(negedge clk); cyc++; end
    if (!halted) chk("watchdog expired", 32'd0, 32'd1);
  endtask

  initial begin
    int pc;
    logic [31:0] ex [0:23];
    logic [15:0] xs, ys;
    int code;
    void'($urandom(32'd20240611));

    // Scenario 1: random arithmetic, logic and compare-set, then SYS
    clear_mem();
    pc = 0;
    for (int k = 0; k < 24; k++) begin
      xs = 16'($urandom); ys = 16'($urandom);
      code = $urandom % 13;
      if (k == 0) begin xs = 16'hFFFF; ys = 16'h0001; code = 9; end  // unsigned LT corner
      if (k == 1) begin xs = 16'h0005; ys = 16'h0005; code = 10; end // LE on equal
      if ((code == 3 || code == 4) && ys == 16'd0) ys = 16'd3;
      mem[pc++] = ei(6'o30, 5'd1, 5'd0, xs);
      mem[pc++] = ei(6'o30, 5'd2, 5'd0, ys);
      if (code < 7) mem[pc++] = e3(opc_of(code), 5'd3, 5'd1, 5'd2);
      else begin
        mem[pc++] = e3(6'o20, 5'd1, 5'd2, 5'd0);
        mem[pc++] = e3(opc_of(code), 5'd3, 5'd0, 5'd0);
      end
      mem[pc++] = ei(6'o32, 5'd0, 5'd3, 16'(16'h0800 + 4 * k));
      ex[k] = exp_of(code, sx(xs), sx(ys));
    end
    mem[pc++] = 32'hE000_0000;                      // SYS
    mem[pc++] = ei(6'o32, 5'd0, 5'd1, 16'h0900);    // store r1 after resume
    mem[pc++] = 32'hFC00_0000;                      // opcode 77: illegal
    run_prog(20000);
    for (int k = 0; k < 24; k++) chk($sformatf("R1/R3 result %0d", k), mem[DATA + k], ex[k]);
    chk("R8 one strobe", sys_cnt, 32'd1);
    chk("R8 strobe carries SP", sys_sp_seen, 32'd4096);
    chk("R8 no request while waiting", stall_bad, 32'd0);
    chk("R8 resumes after SYS", mem[DATA + 64], sx(xs));
    chk("R9 illegal cause", {30'd0, trap_cause}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R9 halt holds", {31'd0, halted}, 32'd1);

    // Scenario 2: stack, call/return and branches, ending in divide by zero
    clear_mem();
    mem[0]  = ei(6'o30, 5'd1, 5'd0, 16'd5);
    mem[1]  = e3(6'o33, 5'd1, 5'd0, 5'd0);
    mem[2]  = ei(6'o30, 5'd1, 5'd0, 16'd7);
    mem[3]  = e3(6'o33, 5'd1, 5'd0, 5'd0);
    mem[4]  = e3(6'o34, 5'd2, 5'd0, 5'd0);
    mem[5]  = e3(6'o34, 5'd3, 5'd0, 5'd0);
    mem[6]  = ei(6'o32, 5'd0, 5'd2, 16'h0800);
    mem[7]  = ei(6'o32, 5'd0, 5'd3, 16'h0804);
    mem[8]  = ei(6'o42, 5'd0, 5'd0, 16'd6);
    mem[9]  = ei(6'o32, 5'd0, 5'd4, 16'h0808);
    mem[10] = ei(6'o40, 5'd0, 5'd0, 16'd2);
    mem[11] = ei(6'o32, 5'd0, 5'd1, 16'h080C);
    mem[12] = ei(6'o40, 5'd1, 5'd0, 16'd5);
    mem[13] = ei(6'o41, 5'd0, 5'd0, 16'd3);
    mem[14] = ei(6'o30, 5'd4, 5'd0, 16'd99);
    mem[15] = 32'h8C00_0000;                        // RET
    mem[16] = ei(6'o32, 5'd0, 5'd1, 16'h0810);
    mem[17] = ei(6'o30, 5'd6, 5'd0, 16'd0);
    mem[18] = e3(6'o03, 5'd7, 5'd1, 5'd6);
    mem[19] = ei(6'o32, 5'd0, 5'd1, 16'h0814);
    run_prog(5000);
    chk("R6 pop order last", mem[DATA], 32'd7);
    chk("R6 pop order first", mem[DATA + 1], 32'd5);
    chk("R6 push below top", mem[1022], 32'd7);
    chk("R5 call pushes return", mem[1023], 32'd36);
    chk("R5 return lands after call", mem[DATA + 2], 32'd99);
    chk("R5 taken branch skips", mem[DATA + 3], FILL);
    chk("R5 untaken branch and jump", mem[DATA + 4], 32'd7);
    chk("R10 divide by zero cause", {30'd0, trap_cause}, 32'd2);
    chk("R10 nothing after trap", mem[DATA + 5], FILL);

    // Scenario 3: pseudo-registers, register 0, out-of-range index
    clear_mem();
    mem[0] = ei(6'o32, 5'd0, 5'd13, 16'h0800);
    mem[1] = ei(6'o32, 5'd0, 5'd14, 16'h0804);
    mem[2] = ei(6'o32, 5'd0, 5'd15, 16'h0808);
    mem[3] = ei(6'o30, 5'd0, 5'd0, 16'd5);
    mem[4] = ei(6'o32, 5'd0, 5'd0, 16'h080C);
    mem[5] = ei(6'o30, 5'd20, 5'd0, 16'd9);
    mem[6] = ei(6'o32, 5'd0, 5'd20, 16'h0810);
    mem[7] = ei(6'o30, 5'd5, 5'd0, 16'h8000);
    mem[8] = ei(6'o32, 5'd0, 5'd5, 16'h0814);
    mem[9] = 32'hFFFF_FFFF;
    run_prog(5000);
    chk("R7 BP reset", mem[DATA], 32'd4096);
    chk("R7 SP reset", mem[DATA + 1], 32'd4096);
    chk("R7 RV reset", mem[DATA + 2], 32'd0);
    chk("R2 r0 write dropped", mem[DATA + 3], 32'd0);
    chk("R2 out-of-range index", mem[DATA + 4], 32'd0);
    chk("R4 sign-extended MOV", mem[DATA + 5], 32'hFFFF_8000);
    chk("R9 all-ones opcode illegal", {30'd0, trap_cause}, 32'd1);

    // Scenario 4: unaligned store and load
    clear_mem();
    mem[0] = ei(6'o30, 5'd1, 5'd0, 16'h0802);
    mem[1] = ei(6'o32, 5'd1, 5'd1, 16'd0);
    mem[2] = ei(6'o32, 5'd0, 5'd1, 16'h0804);
    run_prog(5000);
    chk("R11 unaligned cause", {30'd0, trap_cause}, 32'd3);
    chk("R11 no store at aligned word", mem[DATA], FILL);
    chk("R11 nothing after trap", mem[DATA + 1], FILL);

    // Scenario 5: LW with negative offset
    clear_mem();
    mem[DATA + 2] = 32'h1234_5678;
    mem[0] = ei(6'o30, 5'd1, 5'd0, 16'h0810);
    mem[1] = ei(6'o31, 5'd1, 5'd2, 16'hFFF8);
    mem[2] = ei(6'o32, 5'd0, 5'd2, 16'h0820);
    mem[3] = ei(6'o31, 5'd1, 5'd2, 16'hFFFE);
    run_prog(5000);
    chk("R4 load with negative offset", mem[DATA + 8], 32'h1234_5678);
    chk("R11 unaligned load cause", {30'd0, trap_cause}, 32'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule